// File: doc/BRIEF.md
# Transistor Gain Measurement Sequencer

This block runs the switch network around a remote sensing transistor so that its current gain can be measured. At rest it holds the front end in the normal temperature conversion arrangement. A start pulse runs one gain measurement. The block breaks the current arrangement, sets up the emitter-current path and lets it settle, then asks the ADC for a sample. It then breaks again, sets up the base-current path, lets it settle and takes a second sample. Finally it restores the normal arrangement.

The two ADC codes are kept. An iterative restoring divider turns them into an unsigned Q8.8 gain value equal to emitter code divided by base code, minus one. The result is presented with a ready flag. A zero base code is reported on an error flag. The bias level is set outside this block. To get the gain at several bias currents, software selects a level and pulses start once for each level.

Top module: `gm_gain_seq`

## Requirements
- R1: After reset the switch enables `sw_en` (bit 0 = S1 … bit 4 = S5) equal 5'b00111 (normal conversion), and `adc_req`, `ready`, `gain_err` and `gain` are all zero.
- R2: A start pulse seen while idle opens all switches (`sw_en` = 0) for exactly 2 cycles. The emitter-measurement pattern 5'b10010 (S2, S5) then follows.
- R3: After the emitter reading, all switches open for exactly 2 cycles before the base-measurement pattern 5'b11001 (S1, S4, S5). After the base reading, they open for 2 cycles again before 5'b00111 returns.
- R4: `sw_en` never changes directly from one non-zero pattern to a different non-zero pattern.
- R5: In each measurement pattern, `adc_req` is a one-cycle pulse on the 17th cycle of that pattern, so 16 settling cycles come first. The pattern then holds until `adc_done`.
- R6: The first `adc_data` accepted with `adc_done` is the emitter code E. The second is the base code B.
- R7: `gain` = floor(E·256 / B) − 256, as unsigned Q8.8 with 8 fractional bits.
- R8: A gain above 65535 saturates to 65535. A ratio below one (E < B) gives 0.
- R9: B = 0 sets `gain_err` and forces `gain` to 16'hFFFF.
- R10: `ready` rises when the gain is valid, with `sw_en` back at 5'b00111. A new start clears `ready` and `gain_err`, and the sequence can be repeated any number of times.
- R11: A start pulse during a running measurement is ignored. Exactly two ADC requests are made, and the pattern timing is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to run a gain measurement |
| adc_done | input | 1 | ADC result valid strobe |
| adc_data | input | 12 | ADC result code |
| sw_en | output | 5 | Switch enables, bit 0 = S1 … bit 4 = S5 |
| adc_req | output | 1 | Sample request pulse to the ADC |
| gain | output | 16 | Gain result, unsigned Q8.8 |
| gain_err | output | 1 | Base code was zero |
| ready | output | 1 | Gain result valid |

## Verification
A wrong state or phase shows up at once on `sw_en`. The bench records every pattern segment with its length. A skipped or extra open interval, an overlap of patterns or a swapped pattern therefore differs within one cycle of the fault. A settle counter that is off by one moves `adc_req` by a cycle against the 16-cycle window. Swapped code latches or a faulty divider step only show on `gain` when `ready` rises, about 20 cycles after the base reading. Cases with exact ratios, fractional ratios, saturation, a ratio below one and a zero divisor separate those faults.

// File: rtl/gm_pkg.sv
package gm_pkg;

    localparam logic [4:0] SW_OPEN   = 5'b00000;
    localparam logic [4:0] SW_NORMAL = 5'b00111;
    localparam logic [4:0] SW_EMIT   = 5'b10010;
    localparam logic [4:0] SW_BASE   = 5'b11001;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_SETTLE,
        ST_REQ,
        ST_WAIT,
        ST_DIV
    } gm_state_e;

    // Phase being prepared or measured; during ST_GAP it names the target.
    typedef enum logic [1:0] {
        PH_EMIT,
        PH_BASE,
        PH_NORM
    } gm_phase_e;

    function automatic logic [4:0] sw_for(input gm_phase_e ph);
        case (ph)
            PH_EMIT: sw_for = SW_EMIT;
            PH_BASE: sw_for = SW_BASE;
            default: sw_for = SW_NORMAL;
        endcase
    endfunction

endpackage

// File: rtl/gm_div.sv
module gm_div #(
    parameter int NUM_W = 20,
    parameter int DEN_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [NUM_W-1:0] quot
);
    localparam int CNT_W = $clog2(NUM_W);

    logic             busy;
    logic [CNT_W-1:0] cnt;
    logic [NUM_W-1:0] dvd;
    logic [DEN_W-1:0] rem;
    logic [DEN_W:0]   trial;
    logic             fits;

    assign trial = {rem, dvd[NUM_W-1]};
    assign fits  = trial >= {1'b0, den};

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
            dvd  <= '0;
            rem  <= '0;
            quot <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                busy <= 1'b1;
                cnt  <= '0;
                dvd  <= num;
                rem  <= '0;
                quot <= '0;
            end else if (busy) begin
                rem  <= fits ? DEN_W'(trial - {1'b0, den}) : trial[DEN_W-1:0];
                quot <= {quot[NUM_W-2:0], fits};
                dvd  <= {dvd[NUM_W-2:0], 1'b0};
                cnt  <= cnt + 1'b1;
                if (cnt == CNT_W'(NUM_W - 1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/gm_seq.sv
module gm_seq
    import gm_pkg::*;
#(
    parameter int ADC_W      = 12,
    parameter int GAP_CYC    = 2,
    parameter int SETTLE_CYC = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             adc_done,
    input  logic [ADC_W-1:0] adc_data,
    input  logic             div_done,
    output logic [4:0]       sw_en,
    output logic             adc_req,
    output logic             div_go,
    output logic             idle,
    output logic [ADC_W-1:0] emit_code,
    output logic [ADC_W-1:0] base_code
);
    localparam int MAXC = (GAP_CYC > SETTLE_CYC) ? GAP_CYC : SETTLE_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    gm_state_e       state;
    gm_phase_e       phase;
    logic [CW-1:0]   cnt;
    logic            gap_end;

    assign gap_end = (state == ST_GAP) && (cnt == CW'(GAP_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            phase     <= PH_NORM;
            cnt       <= '0;
            emit_code <= '0;
            base_code <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state <= ST_GAP;
                    phase <= PH_EMIT;
                    cnt   <= '0;
                end
                ST_GAP: begin
                    if (gap_end) begin
                        cnt   <= '0;
                        state <= (phase == PH_NORM) ? ST_DIV : ST_SETTLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_SETTLE: begin
                    if (cnt == CW'(SETTLE_CYC - 1)) begin
                        cnt   <= '0;
                        state <= ST_REQ;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_REQ: state <= ST_WAIT;
                ST_WAIT: if (adc_done) begin
                    state <= ST_GAP;
                    if (phase == PH_EMIT) begin
                        emit_code <= adc_data;
                        phase     <= PH_BASE;
                    end else begin
                        base_code <= adc_data;
                        phase     <= PH_NORM;
                    end
                end
                ST_DIV: if (div_done) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        case (state)
            ST_IDLE, ST_DIV: sw_en = SW_NORMAL;
            ST_GAP:          sw_en = SW_OPEN;
            default:         sw_en = sw_for(phase);
        endcase
    end

    assign adc_req = (state == ST_REQ);
    assign div_go  = gap_end && (phase == PH_NORM);
    assign idle    = (state == ST_IDLE);

endmodule

// File: rtl/gm_gain_seq.sv
module gm_gain_seq
    import gm_pkg::*;
#(
    parameter int ADC_W      = 12,
    parameter int FRAC_W     = 8,
    parameter int GAIN_W     = 16,
    parameter int GAP_CYC    = 2,
    parameter int SETTLE_CYC = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              adc_done,
    input  logic [ADC_W-1:0]  adc_data,
    output logic [4:0]        sw_en,
    output logic              adc_req,
    output logic [GAIN_W-1:0] gain,
    output logic              gain_err,
    output logic              ready
);
    localparam int              QW    = ADC_W + FRAC_W;
    localparam logic [QW-1:0]   ONE_Q = QW'(1) << FRAC_W;
    localparam logic [QW-1:0]   MAX_Q = QW'({GAIN_W{1'b1}});

    logic              div_go, div_done, seq_idle;
    logic [ADC_W-1:0]  emit_code, base_code;
    logic [QW-1:0]     quot, excess;
    logic [GAIN_W-1:0] gain_sat;

    gm_seq #(
        .ADC_W(ADC_W), .GAP_CYC(GAP_CYC), .SETTLE_CYC(SETTLE_CYC)
    ) u_seq (
        .clk(clk), .rst(rst), .start(start),
        .adc_done(adc_done), .adc_data(adc_data),
        .div_done(div_done),
        .sw_en(sw_en), .adc_req(adc_req), .div_go(div_go), .idle(seq_idle),
        .emit_code(emit_code), .base_code(base_code)
    );

    gm_div #(
        .NUM_W(QW), .DEN_W(ADC_W)
    ) u_div (
        .clk(clk), .rst(rst), .go(div_go),
        .num({emit_code, {FRAC_W{1'b0}}}), .den(base_code),
        .done(div_done), .quot(quot)
    );

    // Subtract one (in Q format) and clamp to the output range.
    assign excess = quot - ONE_Q;
    always_comb begin
        if (quot < ONE_Q)         gain_sat = '0;
        else if (excess > MAX_Q)  gain_sat = '1;
        else                      gain_sat = excess[GAIN_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gain     <= '0;
            gain_err <= 1'b0;
            ready    <= 1'b0;
        end else if (start && seq_idle) begin
            ready    <= 1'b0;
            gain_err <= 1'b0;
        end else if (div_done) begin
            ready    <= 1'b1;
            gain_err <= (base_code == '0);
            gain     <= (base_code == '0) ? '1 : gain_sat;
        end
    end

endmodule

// File: rtl/gm_chk.sv
module gm_chk
    import gm_pkg::*;
#(
    parameter int GAIN_W     = 16,
    parameter int SETTLE_CYC = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [4:0]        sw_en,
    input logic              adc_req,
    input logic [GAIN_W-1:0] gain,
    input logic              gain_err,
    input logic              ready
);
    localparam int RW = $clog2(SETTLE_CYC + 3) + 1;

    logic [4:0]    prev_sw;
    logic [RW-1:0] run_q, run;

    assign run = (sw_en == prev_sw) ? ((run_q == '1) ? run_q : run_q + 1'b1) : RW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_sw <= SW_NORMAL;
            run_q   <= '0;
        end else begin
            prev_sw <= sw_en;
            run_q   <= run;
        end
    end

    AST_LEGAL_PATTERN: assert property (@(posedge clk) disable iff (rst)
        (sw_en == SW_OPEN || sw_en == SW_NORMAL || sw_en == SW_EMIT || sw_en == SW_BASE)); // R3
    AST_BREAK_FIRST: assert property (@(posedge clk) disable iff (rst)
        (prev_sw != SW_OPEN && sw_en != prev_sw) |-> (sw_en == SW_OPEN)); // R4
    AST_REQ_AFTER_SETTLE: assert property (@(posedge clk) disable iff (rst)
        adc_req |-> (run == RW'(SETTLE_CYC + 1))); // R5
    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        adc_req |=> !adc_req); // R5
    AST_REQ_IN_MEAS: assert property (@(posedge clk) disable iff (rst)
        adc_req |-> (sw_en == SW_EMIT || sw_en == SW_BASE)); // R5
    AST_ZERO_BASE_SAT: assert property (@(posedge clk) disable iff (rst)
        gain_err |-> (gain == '1)); // R9
    AST_READY_NORMAL: assert property (@(posedge clk) disable iff (rst)
        ready |-> (sw_en == SW_NORMAL && !adc_req)); // R10

endmodule

bind gm_gain_seq gm_chk #(
    .GAIN_W(GAIN_W), .SETTLE_CYC(SETTLE_CYC)
) u_chk (
    .clk(clk), .rst(rst), .sw_en(sw_en), .adc_req(adc_req),
    .gain(gain), .gain_err(gain_err), .ready(ready)
);

// File: tb/tb_gm_gain_seq.sv
module tb_gm_gain_seq;
    localparam int CLK_PERIOD = 10;
    localparam logic [4:0] P_OPEN = 5'b00000, P_NORM = 5'b00111,
                           P_EMIT = 5'b10010, P_BASE = 5'b11001;

    logic        clk = 1'b0, rst = 1'b1, start = 1'b0, adc_done = 1'b0;
    logic [11:0] adc_data = '0;
    logic [4:0]  sw_en;
    logic        adc_req, gain_err, ready;
    logic [15:0] gain;

    int n_chk = 0, n_fail = 0;

    gm_gain_seq dut (
        .clk(clk), .rst(rst), .start(start), .adc_done(adc_done),
        .adc_data(adc_data), .sw_en(sw_en), .adc_req(adc_req),
        .gain(gain), .gain_err(gain_err), .ready(ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_gain(input int e, input int b);
        int q;
        if (b == 0) return 65535;
        q = (e * 256) / b;
        if (q < 256) return 0;
        q = q - 256;
        return (q > 65535) ? 65535 : q;
    endfunction

    // Run one measurement; stray = cycle index of an extra start pulse (-1: none).
    task automatic run_meas(input int e, input int b, input int stray);
        int seg_val[8], seg_len[8];
        int n = 0, cur, len, reqs = 0, pend = -1, pre_req[2];
        bit fin = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(ready == 1'b0, "R10 ready cleared by start", ready, 0);
        cur = sw_en; len = 0;
        for (int i = 0; i < 400 && !fin; i++) begin
            if (i > 0) @(negedge clk);
            adc_done = 1'b0;
            start    = (i == stray);
            if (sw_en != cur[4:0]) begin
                if (n < 8) begin seg_val[n] = cur; seg_len[n] = len; end
                n++; cur = sw_en; len = 1;
            end else len++;
            if (adc_req) begin
                if (reqs < 2) pre_req[reqs] = len - 1;
                reqs++; pend = 3;
            end else if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    adc_done = 1'b1;
                    adc_data = (reqs == 1) ? 12'(e) : 12'(b);
                    pend = -1;
                end
            end
            if (ready) fin = 1;
        end
        start = 1'b0; adc_done = 1'b0;
        if (n < 8) begin seg_val[n] = cur; seg_len[n] = len; end
        n++;
        chk(fin, "R10 ready reached", fin, 1);
        chk(reqs == 2, "R11 request count", reqs, 2);
        chk(n == 6, "R3 segment count", n, 6);
        if (n == 6) begin
            chk(seg_val[0] == P_OPEN && seg_len[0] == 2, "R2 first open gap", seg_len[0], 2);
            chk(seg_val[1] == P_EMIT, "R2 emitter pattern", seg_val[1], P_EMIT);
            chk(seg_val[2] == P_OPEN && seg_len[2] == 2, "R3 second open gap", seg_len[2], 2);
            chk(seg_val[3] == P_BASE, "R3 base pattern", seg_val[3], P_BASE);
            chk(seg_val[4] == P_OPEN && seg_len[4] == 2, "R3 third open gap", seg_len[4], 2);
            chk(seg_val[5] == P_NORM, "R10 normal restored", seg_val[5], P_NORM);
            chk(seg_len[1] > 17 && seg_len[3] > 17, "R5 pattern held to done", seg_len[1], 18);
        end
        if (reqs == 2) begin
            chk(pre_req[0] == 16, "R5 emitter settle", pre_req[0], 16);
            chk(pre_req[1] == 16, "R5 base settle", pre_req[1], 16);
        end
        chk(gain == 16'(exp_gain(e, b)), "R7 gain value", gain, exp_gain(e, b));
        chk(gain_err == (b == 0), "R9 error flag", gain_err, int'(b == 0));
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(sw_en == P_NORM, "R1 reset switches", sw_en, P_NORM);
        chk(!adc_req && !ready && !gain_err, "R1 reset flags", {adc_req, ready, gain_err}, 0);
        chk(gain == 0, "R1 reset gain", gain, 0);
    endtask

    task automatic t_exact();    run_meas(1010, 10, -1);
        chk(gain == 16'h6400, "R6 R7 exact ratio", gain, 16'h6400); endtask
    task automatic t_fraction(); run_meas(1000, 7, -1); endtask
    task automatic t_order();    run_meas(100, 400, -1);
        chk(gain == 0, "R6 R8 codes not swapped", gain, 0); endtask
    task automatic t_saturate(); run_meas(4095, 1, -1);
        chk(gain == 16'hFFFF && !gain_err, "R8 saturation", gain, 65535); endtask
    task automatic t_zero();     run_meas(300, 0, -1);
        chk(gain == 16'hFFFF, "R9 zero base", gain, 65535); endtask
    task automatic t_recover();  run_meas(2000, 1000, -1);
        chk(gain == 16'h0100 && !gain_err, "R10 repeat clears error", gain, 256); endtask
    task automatic t_busy();     run_meas(2000, 100, 6);
        run_meas(1500, 300, 30); endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_exact();
        t_fraction();
        t_order();
        t_saturate();
        t_zero();
        t_recover();
        t_busy();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule